// File: doc/BRIEF.md
# Clock prescaler with selectable periodic interrupt

This block divides a 32.768 kHz system clock through a fifteen-stage binary chain and offers every stage output as a divided clock tap for neighbouring peripherals. Software picks one of three taps (32 Hz, 8 Hz or 1 Hz) as the source of a periodic interrupt, or turns the interrupt off, through a 4-bit control register. Each rising edge of the chosen tap raises a single-cycle interrupt request.

The same register holds a mask bit for a timer/counter interrupt. The block only stores and exports this bit. It also holds a self-clearing restart bit. Writing 1 to the restart bit returns every divider stage to zero. A watchdog block can use the 1 Hz tap output and the one-cycle restart event output.

Top module: `clk_prescaler`

## Requirements
- R1: After synchronous active-low reset, div_taps, rd_data, irq, tmr_mask and clr_evt are all 0.
- R2: div_taps is a 15-bit binary count that rises by one on every clock and wraps from 32767 to 0. Stage k of the chain is div_taps[k-1].
- R3: The 32 Hz tap is div_taps[9] (stage 10), the 8 Hz tap is div_taps[11] (stage 12) and the 1 Hz tap is div_taps[14] (stage 15). tick_1hz always equals div_taps[14].
- R4: With rate code rd_data[1:0] = 00, irq stays 0.
- R5: With rate code 01 (1 Hz), 10 (8 Hz) or 11 (32 Hz), irq goes high for exactly one cycle. This happens in the cycle after the first cycle in which the selected tap reads 1, so for 32 Hz after a restart it is the cycle in which div_taps reads 513.
- R6: A write with wr_en high stores wr_data[3] as the mask and wr_data[1:0] as the rate code. rd_data returns {mask, 0, rate code}, so bit 2 always reads 0.
- R7: A write with wr_data[2] = 1 sets div_taps to 0 in the next cycle, and clr_evt is high in that cycle only. A write with wr_data[2] = 0 leaves the count running.
- R8: Changing the rate code, or restarting the chain, never produces an irq pulse without a rising edge of the selected tap. Selecting a tap that is already high gives no pulse.
- R9: tmr_mask always equals the stored mask bit, rd_data[3].

Top module ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 32.768 kHz system clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Control register write strobe |
| wr_data | input | 4 | Write data: [3] mask, [2] restart, [1:0] rate code |
| rd_data | output | 4 | Control register read value |
| div_taps | output | 15 | All divider stage outputs |
| tick_1hz | output | 1 | 1 Hz tap for a watchdog |
| irq | output | 1 | One-cycle periodic interrupt request |
| tmr_mask | output | 1 | Stored timer/counter interrupt mask |
| clr_evt | output | 1 | One-cycle pulse after a chain restart |

## Verification
A divider that skips, sticks or fails to clear shows up at div_taps on the next clock, because the whole chain is visible on the port every cycle. A wrong tap history or a wrong rate decode shows up at irq only at the next edge of a tap. That can be up to 32768 cycles away for the 1 Hz rate, so the bench runs full periods of each rate. It also switches the code while a tap is high, to expose pulses that come from the selection and not from the count.

// File: rtl/prsc_pkg.sv
// Shared types and field positions for the clock prescaler.
// Assumes a 4-bit control word: mask, restart, two rate-code bits.
package prsc_pkg;

    typedef enum logic [1:0] {
        RATE_OFF  = 2'b00,
        RATE_SLOW = 2'b01,
        RATE_MID  = 2'b10,
        RATE_FAST = 2'b11
    } rate_e;

    localparam int CTRL_W   = 4;
    localparam int BIT_MASK = 3;
    localparam int BIT_CLR  = 2;
    localparam int NUM_TAPS = 3;

endpackage

// File: rtl/prsc_ctrl_reg.sv
// Control register of the prescaler.
// Holds the rate code and the timer mask. It decodes the self-clearing
// restart bit into a combinational request that lasts as long as the write.
// Assumes at most one write per clock and synchronous active-low reset.
module prsc_ctrl_reg
    import prsc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [CTRL_W-1:0] wr_data,
    output rate_e             rate,
    output logic              tmr_mask,
    output logic              clr_req,
    output logic [CTRL_W-1:0] rd_data
);

    rate_e rate_q;
    logic  mask_q;

    // Store the rate code and the mask on every write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rate_q <= RATE_OFF;
            mask_q <= 1'b0;
        end else if (wr_en) begin
            rate_q <= rate_e'(wr_data[1:0]);
            mask_q <= wr_data[BIT_MASK];
        end
    end

    // The restart bit has no storage, so it reads back as zero.
    always_comb begin
        clr_req  = wr_en & wr_data[BIT_CLR];
        rd_data  = {mask_q, 1'b0, rate_q};
        rate     = rate_q;
        tmr_mask = mask_q;
    end

endmodule

// File: rtl/prsc_divider.sv
// Binary divider chain. Bit k-1 of the count is the output of stage k.
// A clear request zeroes all stages at the next edge, and a one-cycle
// event marks the cycle in which the count reads zero after it.
module prsc_divider #(
    parameter int STAGES = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    output logic [STAGES-1:0] cnt,
    output logic              clr_evt
);

    logic [STAGES-1:0] cnt_q;
    logic              evt_q;

    // Count up every cycle, or restart from zero on request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            evt_q <= 1'b0;
        end else begin
            cnt_q <= clr ? '0 : cnt_q + STAGES'(1);
            evt_q <= clr;
        end
    end

    assign cnt     = cnt_q;
    assign clr_evt = evt_q;

    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(clr)) |-> cnt_q == $past(cnt_q) + STAGES'(1)); // R2
    AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(clr)) |-> (cnt_q == '0 && evt_q)); // R7

endmodule

// File: rtl/prsc_irq_gen.sv
// Periodic interrupt generator.
// Each tap keeps its own one-cycle history, so a change of the selected
// tap can never look like an edge. The request is registered and lasts
// one cycle. Assumes tap periods of several cycles.
module prsc_irq_gen
    import prsc_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_TAPS-1:0] taps,   // [0] fast, [1] mid, [2] slow
    input  rate_e               rate,
    output logic                irq
);

    logic [NUM_TAPS-1:0] tap_prev_q;
    logic [NUM_TAPS-1:0] rise;
    logic                rise_sel;
    logic                irq_q;

    // Remember the previous level of every tap.
    always_ff @(posedge clk) begin
        if (!rst_n) tap_prev_q <= '0;
        else        tap_prev_q <= taps;
    end

    // Detect each tap's rising edge on its own history.
    for (genvar g = 0; g < NUM_TAPS; g++) begin : g_rise
        assign rise[g] = taps[g] & ~tap_prev_q[g];
    end

    // Select the edge of the tap named by the rate code.
    always_comb begin
        unique case (rate)
            RATE_FAST: rise_sel = rise[0];
            RATE_MID:  rise_sel = rise[1];
            RATE_SLOW: rise_sel = rise[2];
            default:   rise_sel = 1'b0;
        endcase
    end

    // Register the request so that it is a clean one-cycle pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= rise_sel;
    end

    assign irq = irq_q;

    AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_q |=> !irq_q); // R5
    AST_IRQ_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        irq_q |-> $past(rate) != RATE_OFF); // R4
    AST_IRQ_NEEDS_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_q |-> $past(taps) != $past(tap_prev_q)); // R8

endmodule

// File: rtl/clk_prescaler.sv
// Clock prescaler top.
// Joins the control register, the divider chain and the interrupt
// generator, and exports all stage outputs plus the watchdog signals.
// Stage numbers count from 1, and stage k is count bit k-1.
module clk_prescaler
    import prsc_pkg::*;
#(
    parameter int STAGES   = 15,
    parameter int STG_FAST = 10,
    parameter int STG_MID  = 12,
    parameter int STG_SLOW = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [3:0]        wr_data,
    output logic [3:0]        rd_data,
    output logic [STAGES-1:0] div_taps,
    output logic              tick_1hz,
    output logic              irq,
    output logic              tmr_mask,
    output logic              clr_evt
);

    rate_e               rate;
    logic                clr_req;
    logic [STAGES-1:0]   cnt;
    logic [NUM_TAPS-1:0] tap_sel;

    prsc_ctrl_reg u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .rate     (rate),
        .tmr_mask (tmr_mask),
        .clr_req  (clr_req),
        .rd_data  (rd_data)
    );

    prsc_divider #(.STAGES(STAGES)) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (clr_req),
        .cnt     (cnt),
        .clr_evt (clr_evt)
    );

    // Pick out the three interrupt taps by stage number.
    assign tap_sel  = {cnt[STG_SLOW-1], cnt[STG_MID-1], cnt[STG_FAST-1]};
    assign div_taps = cnt;
    assign tick_1hz = cnt[STG_SLOW-1];

    prsc_irq_gen u_irq (
        .clk   (clk),
        .rst_n (rst_n),
        .taps  (tap_sel),
        .rate  (rate),
        .irq   (irq)
    );

    AST_EVT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        clr_evt |-> div_taps == '0); // R7
    AST_MASK_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_mask == rd_data[3]); // R9

endmodule

// File: tb/clk_prescaler_bench.sv
module clk_prescaler_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_data = 4'h0;
    logic [3:0]  rd_data;
    logic [14:0] div_taps;
    logic        tick_1hz, irq, tmr_mask, clr_evt;

    int checks = 0;
    int errors = 0;
    bit chk_on = 1'b0;
    bit done = 1'b0;

    clk_prescaler u_clk_prescaler (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .div_taps(div_taps), .tick_1hz(tick_1hz),
        .irq(irq), .tmr_mask(tmr_mask), .clr_evt(clr_evt)
    );

    always #10 clk = ~clk;

    // Reference model built from the requirements.
    logic [14:0] m_cnt = '0, m_cnt_prev = '0;
    logic [1:0]  m_rate = 2'b00;
    logic        m_mask = 1'b0, m_irq = 1'b0, m_evt = 1'b0;

    function automatic logic tap_of(input logic [14:0] c, input logic [1:0] r);
        case (r)
            2'b01:   return c[14];
            2'b10:   return c[11];
            2'b11:   return c[9];
            default: return 1'b0;
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt <= '0; m_cnt_prev <= '0; m_rate <= 2'b00;
            m_mask <= 1'b0; m_irq <= 1'b0; m_evt <= 1'b0;
        end else begin
            m_irq      <= tap_of(m_cnt, m_rate) & ~tap_of(m_cnt_prev, m_rate);
            m_cnt_prev <= m_cnt;
            m_cnt      <= (wr_en && wr_data[2]) ? 15'd0 : m_cnt + 15'd1;
            m_evt      <= wr_en && wr_data[2];
            if (wr_en) begin
                m_rate <= wr_data[1:0];
                m_mask <= wr_data[3];
            end
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Compare every output with the model between clock edges.
    always @(negedge clk) begin
        if (chk_on) begin
            check(div_taps == m_cnt, "R2", div_taps, m_cnt);
            check(tick_1hz == m_cnt[14], "R3", tick_1hz, m_cnt[14]);
            check(irq == m_irq, (m_rate == 2'b00) ? "R4" : "R5", irq, m_irq);
            check(rd_data == {m_mask, 1'b0, m_rate}, "R6", rd_data, {m_mask, 1'b0, m_rate});
            check(tmr_mask == m_mask, "R9", tmr_mask, m_mask);
            check(clr_evt == m_evt, "R7", clr_evt, m_evt);
        end
    end

    task automatic wr(input logic [3:0] d);
        wr_en = 1'b1; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_data = 4'h0;
    endtask

    task automatic wait_taps(input logic [14:0] v);
        while (div_taps != v) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (190000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual %0d expected %0d", 190000, 0);
        finish_run();
    end

    initial begin
        int seed_dummy;
        int pulses;
        seed_dummy = $urandom(32'd1234);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state (one clock after release the count is 1)
        check(rd_data == 4'h0 && irq == 1'b0 && tmr_mask == 1'b0 && clr_evt == 1'b0,
              "R1", {rd_data, irq, tmr_mask, clr_evt}, 0);
        check(div_taps == 15'd1, "R1", div_taps, 1);
        chk_on = 1'b1;

        // R6: register write and readback, restart bit reads 0
        wr(4'b1110);
        check(rd_data == 4'b1010, "R6", rd_data, 4'b1010);
        check(tmr_mask == 1'b1, "R9", tmr_mask, 1);
        check(div_taps == 15'd0 && clr_evt, "R7", div_taps, 0);

        // R5: 32 Hz edge timing after a restart
        wr(4'b0111);
        wait_taps(15'd512);
        check(irq == 1'b0, "R5", irq, 0);
        @(negedge clk);
        check(irq == 1'b1 && div_taps == 15'd513, "R5", irq, 1);
        @(negedge clk);
        check(irq == 1'b0, "R5", irq, 0);
        repeat (1600) @(negedge clk);

        // R7: a write without the restart bit keeps counting
        wait_taps(15'd100);
        wr(4'b0011);
        check(div_taps == 15'd101, "R7", div_taps, 101);
        wait_taps(15'd200);
        wr(4'b0011 | 4'b0100);
        check(div_taps == 15'd0 && clr_evt == 1'b1, "R7", div_taps, 0);
        @(negedge clk);
        check(div_taps == 15'd1 && clr_evt == 1'b0, "R7", clr_evt, 0);

        // R8: select 8 Hz while that tap is already high, no pulse
        wait_taps(15'd2100);
        wr(4'b0010);
        pulses = 0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (irq) pulses++;
        end
        check(pulses == 0, "R8", pulses, 0);
        // R8: restart while the 8 Hz tap is high, no pulse
        wait_taps(15'd3000);
        wr(4'b0110);
        pulses = 0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (irq) pulses++;
        end
        check(pulses == 0, "R8", pulses, 0);
        repeat (8500) @(negedge clk);

        // R3 / R5: a full 1 Hz period including the wrap of the chain
        wr(4'b0101);
        pulses = 0;
        for (int i = 0; i < 33000; i++) begin
            @(negedge clk);
            if (irq) pulses++;
        end
        check(pulses == 1, "R3", pulses, 1);

        // R4: interrupt disabled over many fast-tap edges
        wr(4'b1000);
        pulses = 0;
        for (int i = 0; i < 5000; i++) begin
            @(negedge clk);
            if (irq) pulses++;
        end
        check(pulses == 0, "R4", pulses, 0);

        // Random mix of writes and long idle runs, checked each cycle.
        for (int i = 0; i < 45000; i++) begin
            if ($urandom % 3000 == 0) begin
                wr(4'($urandom) & (($urandom % 4 == 0) ? 4'hF : 4'hB));
            end else begin
                @(negedge clk);
            end
        end

        chk_on = 1'b0;
        finish_run();
    end

endmodule